// File: doc/BRIEF.md
# I2C Byte Transaction Sequencer with Retry

This block carries out one complete single-byte register access on an I2C bus: either a random read of one register or a write of one register. A bit-level line engine does the actual drive and sampling of SCL and SDA. The sequencer only decides which line operation comes next. It presents one command at a time to the engine and waits for the engine's completion pulse before it moves on. Bytes leave and arrive most significant bit first.

A read first addresses the device in write form and sends the register offset. It then issues a repeated START, addresses the device again with the read bit set, shifts in eight bits and closes with a NACK and a STOP. A write sends the address, the offset and the data byte, each followed by an acknowledge check, and then a STOP. Two things abort an attempt: a missing acknowledge, or a sent bit that the engine reports could not be set on the line. The sequencer then commands a bus clear, waits a back-off period counted in microsecond ticks, and tries again. It keeps trying until the per-operation budget is spent: ten attempts for a read, one for a write.

States: IDLE, START, SEND, RELEASE, ACKCHK, RECV, NACK, STOP, CLEAR, BACKOFF. The transitions are:
- IDLE→START when a request is accepted.
- START→SEND when the engine completes the START. This loads the write-form address, or the read-form address after the repeated START.
- SEND→SEND for each further bit.
- SEND→RELEASE after the eighth bit, or at once when a sent bit fails.
- RELEASE→ACKCHK, or RELEASE→CLEAR if the byte was aborted.
- ACKCHK→CLEAR on a missing acknowledge.
- ACKCHK→SEND for the next byte, ACKCHK→START for the repeated START of a read, ACKCHK→RECV after the read-form address, and ACKCHK→STOP after the write data.
- RECV→RECV for each further bit, then RECV→NACK.
- NACK→STOP, or NACK→CLEAR if the NACK bit fails.
- STOP→IDLE with success.
- CLEAR→BACKOFF.
- BACKOFF→START while attempts remain, and BACKOFF→IDLE with failure once the budget is spent.

Top module: `i2c_byte_xact_seq`

## Requirements
- R1: The line-command codes on cmd_op are: 0 START, 1 STOP, 2 send bit (value on cmd_bit), 3 receive bit, 4 acknowledge check, 5 release SDA, 6 bus clear. A read attempt issues, in order: START, the 8 bits of dev_addr, release, ack check, the 8 bits of reg_off, release, ack check, START, the 8 bits of dev_addr with bit 0 forced to 1, release, ack check, 8 receive bits, one send bit of value 1, STOP.
- R2: A write attempt issues, in order: START, the 8 bits of dev_addr, release, ack check, the 8 bits of reg_off, release, ack check, the 8 bits of wr_data, release, ack check, STOP.
- R3: Every byte is sent bit 7 first. rd_data is cleared when a request is accepted and again at the start of each attempt. Received bits are shifted in from the low end, so the first bit received ends up in bit 7. After a successful read, rd_data equals the received byte. After any write, rd_data is 0.
- R4: A release command follows each sent byte before its acknowledge check. This holds also when the byte was cut short by a failed bit: the release follows the failed bit at once and no ack check comes after it.
- R5: An attempt is aborted by either of two things. One is an ack check that completes with eng_bit=1, meaning no acknowledge. The other is a send-bit command that completes with eng_err=1. After the abort the sequencer issues a bus clear and then waits exactly BACKOFF_US rising us_tick cycles, counted after the bus clear completes, before it either issues the next START or finishes.
- R6: A read is attempted at most RD_TRIES times (default 10) and a write at most WR_TRIES times (default 1). fail is 1 with done only if the last permitted attempt failed.
- R7: bb_en goes high on the cycle after a request is accepted, stays high through every command and back-off, and is low from the cycle done is high.
- R8: A request while bb_en is high is ignored. It changes neither the command sequence nor the result, and it causes no second done.
- R9: done is high for exactly one cycle per accepted request, and fail and rd_data are valid in that cycle.
- R10: A command stays valid with unchanged cmd_op and cmd_bit until the engine pulses eng_ack.
- R11: After reset, bb_en, done, fail and cmd_valid are 0 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond, paces the back-off |
| req | input | 1 | Start a transaction (accepted only when idle) |
| req_rd | input | 1 | 1 selects read, 0 selects write |
| dev_addr | input | 8 | Device address byte in write form (bit 0 = 0) |
| reg_off | input | 8 | Register offset byte |
| wr_data | input | 8 | Data byte for a write |
| rd_data | output | 8 | Byte received by a read |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | With done: 1 when every permitted attempt failed |
| bb_en | output | 1 | High for the whole transaction |
| cmd_valid | output | 1 | A line command is presented to the engine |
| cmd_op | output | 3 | Line command code |
| cmd_bit | output | 1 | Bit value for a send command |
| eng_ack | input | 1 | Engine finished the current command (one cycle) |
| eng_bit | input | 1 | Received bit, or SDA level at ack check (0 = acknowledged) |
| eng_err | input | 1 | With eng_ack on a send: the bit could not be set |

## Verification
The bench targets failures at every abort point:
- NACK on each of the three acknowledge checks.
- A bad bit in the middle of a byte, which has to produce a release and no acknowledge check.
- A bad final NACK bit, which has to go straight to bus clear.

A sequencer that skips the release on a truncated byte, or that keeps sending after a bad bit, changes the logged command stream. The retry boundaries are run explicitly:
- a read that succeeds on its tenth attempt;
- a read that fails all ten;
- a write that gets no retry at all.

An off-by-one budget shows up as a wrong fail flag or a wrong bus-clear count. The back-off is measured in ticks after each bus clear, which catches a timer that is one tick short or long. Requests pulsed in the middle of a transaction would cause a second done or a corrupted stream if they were not ignored.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_STOP    = 3'd1,
        OP_SEND    = 3'd2,
        OP_RECV    = 3'd3,
        OP_ACKCHK  = 3'd4,
        OP_RELEASE = 3'd5,
        OP_CLEAR   = 3'd6
    } line_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_SEND,
        ST_RELEASE,
        ST_ACKCHK,
        ST_RECV,
        ST_NACK,
        ST_STOP,
        ST_CLEAR,
        ST_BACKOFF
    } seq_state_e;

    // Which byte the current SEND/ACKCHK pair belongs to
    typedef enum logic [1:0] {
        PH_ADDR_W,
        PH_OFFSET,
        PH_WDATA,
        PH_ADDR_R
    } seq_phase_e;

endpackage

// File: rtl/i2c_seq_backoff.sv
module i2c_seq_backoff #(
    parameter int COUNT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(COUNT + 1);

    logic [CW-1:0] remain;
    logic          run;

    assign expire = run && tick && (remain == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run    <= 1'b0;
            remain <= '0;
        end else if (start) begin
            run    <= 1'b1;
            remain <= CW'(COUNT);
        end else if (run && tick) begin
            remain <= remain - CW'(1);
            if (remain == CW'(1)) begin
                run <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_byte_xact_seq.sv
module i2c_byte_xact_seq
    import i2c_seq_pkg::*;
#(
    parameter int RD_TRIES   = 10,
    parameter int WR_TRIES   = 1,
    parameter int BACKOFF_US = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       req,
    input  logic       req_rd,
    input  logic [7:0] dev_addr,
    input  logic [7:0] reg_off,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       done,
    output logic       fail,
    output logic       bb_en,
    output logic       cmd_valid,
    output logic [2:0] cmd_op,
    output logic       cmd_bit,
    input  logic       eng_ack,
    input  logic       eng_bit,
    input  logic       eng_err
);
    localparam int TRY_MAX = (RD_TRIES > WR_TRIES) ? RD_TRIES : WR_TRIES;
    localparam int TW      = $clog2(TRY_MAX + 1);

    seq_state_e state;
    seq_phase_e phase;
    logic       op_rd;
    logic       abort;
    logic [7:0] addr_q, off_q, wdata_q, shreg;
    logic [2:0] bit_cnt;
    logic [TW-1:0] tries_q;
    logic [TW-1:0] try_limit;
    logic       bo_start, bo_expire;

    assign try_limit = op_rd ? TW'(RD_TRIES) : TW'(WR_TRIES);
    assign bo_start  = (state == ST_CLEAR) && eng_ack;

    i2c_seq_backoff #(.COUNT(BACKOFF_US)) u_backoff (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (bo_start),
        .tick   (us_tick),
        .expire (bo_expire)
    );

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR_W;
            op_rd   <= 1'b0;
            abort   <= 1'b0;
            addr_q  <= '0;
            off_q   <= '0;
            wdata_q <= '0;
            shreg   <= '0;
            bit_cnt <= '0;
            tries_q <= '0;
            rd_data <= '0;
            done    <= 1'b0;
            fail    <= 1'b0;
            bb_en   <= 1'b0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            unique case (state)
                ST_IDLE: if (req) begin
                    op_rd   <= req_rd;
                    addr_q  <= dev_addr;
                    off_q   <= reg_off;
                    wdata_q <= wr_data;
                    tries_q <= '0;
                    rd_data <= '0;
                    phase   <= PH_ADDR_W;
                    bb_en   <= 1'b1;
                    state   <= ST_START;
                end
                ST_START: if (eng_ack) begin
                    shreg   <= (phase == PH_ADDR_R) ? (addr_q | 8'h01) : addr_q;
                    bit_cnt <= 3'd7;
                    abort   <= 1'b0;
                    if (phase == PH_ADDR_W) begin
                        rd_data <= '0;
                    end
                    state   <= ST_SEND;
                end
                ST_SEND: if (eng_ack) begin
                    shreg   <= {shreg[6:0], 1'b0};
                    bit_cnt <= bit_cnt - 3'd1;
                    if (eng_err) begin
                        abort <= 1'b1;
                        state <= ST_RELEASE;
                    end else if (bit_cnt == 3'd0) begin
                        state <= ST_RELEASE;
                    end
                end
                ST_RELEASE: if (eng_ack) begin
                    state <= abort ? ST_CLEAR : ST_ACKCHK;
                end
                ST_ACKCHK: if (eng_ack) begin
                    if (eng_bit) begin
                        state <= ST_CLEAR;
                    end else begin
                        unique case (phase)
                            PH_ADDR_W: begin
                                shreg   <= off_q;
                                bit_cnt <= 3'd7;
                                phase   <= PH_OFFSET;
                                state   <= ST_SEND;
                            end
                            PH_OFFSET: begin
                                if (op_rd) begin
                                    phase <= PH_ADDR_R;
                                    state <= ST_START;
                                end else begin
                                    shreg   <= wdata_q;
                                    bit_cnt <= 3'd7;
                                    phase   <= PH_WDATA;
                                    state   <= ST_SEND;
                                end
                            end
                            PH_WDATA: state <= ST_STOP;
                            PH_ADDR_R: begin
                                bit_cnt <= 3'd7;
                                state   <= ST_RECV;
                            end
                        endcase
                    end
                end
                ST_RECV: if (eng_ack) begin
                    rd_data <= {rd_data[6:0], eng_bit};
                    bit_cnt <= bit_cnt - 3'd1;
                    if (bit_cnt == 3'd0) begin
                        state <= ST_NACK;
                    end
                end
                ST_NACK: if (eng_ack) begin
                    state <= eng_err ? ST_CLEAR : ST_STOP;
                end
                ST_STOP: if (eng_ack) begin
                    bb_en <= 1'b0;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                ST_CLEAR: if (eng_ack) begin
                    tries_q <= tries_q + TW'(1);
                    state   <= ST_BACKOFF;
                end
                ST_BACKOFF: if (bo_expire) begin
                    if (tries_q >= try_limit) begin
                        bb_en <= 1'b0;
                        done  <= 1'b1;
                        fail  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        phase <= PH_ADDR_W;
                        state <= ST_START;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Command outputs
    always_comb begin
        cmd_valid = 1'b1;
        cmd_op    = OP_START;
        cmd_bit   = 1'b1;
        unique case (state)
            ST_START:   cmd_op = OP_START;
            ST_SEND:    begin cmd_op = OP_SEND; cmd_bit = shreg[7]; end
            ST_RELEASE: cmd_op = OP_RELEASE;
            ST_ACKCHK:  cmd_op = OP_ACKCHK;
            ST_RECV:    cmd_op = OP_RECV;
            ST_NACK:    begin cmd_op = OP_SEND; cmd_bit = 1'b1; end
            ST_STOP:    cmd_op = OP_STOP;
            ST_CLEAR:   cmd_op = OP_CLEAR;
            default:    cmd_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_seq_checker.sv
module i2c_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       done,
    input logic       fail,
    input logic       bb_en,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       cmd_bit,
    input logic       eng_ack
);
    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !eng_ack) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bit)));

    assert_cmd_in_txn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> bb_en);

    assert_en_low_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bb_en);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fail_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    assert_start_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bb_en) |-> $past(req));
endmodule

bind i2c_byte_xact_seq i2c_seq_checker u_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .done      (done),
    .fail      (fail),
    .bb_en     (bb_en),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bit   (cmd_bit),
    .eng_ack   (eng_ack)
);

// File: tb/test_i2c_byte_xact_seq.sv
`timescale 1ns/1ps
module test_i2c_byte_xact_seq;
    localparam int BO      = 3;
    localparam int RDT     = 10;
    localparam int WRT     = 1;
    localparam int LOGSZ   = 1024;
    localparam int C_START = 0, C_STOP = 1, C_SEND = 2, C_RECV = 3,
                   C_ACK = 4, C_REL = 5, C_CLEAR = 6;

    logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, req = 1'b0, req_rd = 1'b0;
    logic [7:0] dev_addr = '0, reg_off = '0, wr_data = '0;
    logic [7:0] rd_data;
    logic done, fail, bb_en, cmd_valid, cmd_bit;
    logic [2:0] cmd_op;
    logic eng_ack = 1'b0, eng_bit = 1'b0, eng_err = 1'b0;

    always #2 clk = ~clk;

    i2c_byte_xact_seq #(.RD_TRIES(RDT), .WR_TRIES(WRT), .BACKOFF_US(BO)) i_i2c_byte_xact_seq (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req(req), .req_rd(req_rd),
        .dev_addr(dev_addr), .reg_off(reg_off), .wr_data(wr_data), .rd_data(rd_data),
        .done(done), .fail(fail), .bb_en(bb_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .eng_ack(eng_ack), .eng_bit(eng_bit), .eng_err(eng_err)
    );

    int n_chk = 0, n_err = 0, cyc = 0, tick_div = 0;
    int attempt, tx_i, ack_i, wait_c = 0, f_n, f_kind, f_pos;
    logic [7:0] slave_val;
    int log_op [LOGSZ];
    bit log_bit [LOGSZ];
    int log_n = 0;
    int exp_op [LOGSZ];
    bit exp_bit [LOGSZ];
    int exp_n = 0;
    int rx_i = 0;
    int bo_ticks = 0, bo_bad = 0, en_bad = 0, done_cnt = 0;
    bit bo_active = 0, bo_skip = 0, done_fail = 0;
    logic [7:0] done_rd = '0;

    task automatic summary_and_end();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // Engine model, monitor and tick generator, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary_and_end();
        end
        if (done) begin
            done_cnt++;
            done_fail = fail;
            done_rd   = rd_data;
        end
        if (bo_active) begin
            if (bo_skip) bo_skip = 0;
            else begin
                if (us_tick) bo_ticks++;
                if (cmd_valid || done) begin
                    if (bo_ticks != BO) bo_bad++;
                    bo_active = 0;
                end
            end
        end
        if (eng_ack) begin
            eng_ack = 0; eng_bit = 0; eng_err = 0;
        end else if (cmd_valid) begin
            if (wait_c < 2) wait_c++;
            else begin
                wait_c = 0;
                if (!bb_en) en_bad++;
                if (log_n < LOGSZ) begin
                    log_op[log_n] = int'(cmd_op); log_bit[log_n] = cmd_bit; log_n++;
                end
                eng_bit = 0; eng_err = 0;
                case (int'(cmd_op))
                    C_START: ;
                    C_SEND: begin
                        eng_err = (attempt < f_n) && (f_kind == 1) && (tx_i == f_pos);
                        tx_i++;
                    end
                    C_ACK: begin
                        eng_bit = (attempt < f_n) && (f_kind == 0) && (ack_i == f_pos);
                        ack_i++;
                    end
                    C_RECV: begin
                        eng_bit = slave_val[7 - rx_i];
                        rx_i++;
                    end
                    C_CLEAR: begin
                        attempt++; tx_i = 0; ack_i = 0; rx_i = 0;
                        bo_active = 1; bo_skip = 1; bo_ticks = 0;
                    end
                    default: ;
                endcase
                eng_ack = 1;
            end
        end
        tick_div++;
        us_tick = (tick_div % 4 == 0);
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic e_push(input int op, input bit b);
        exp_op[exp_n] = op; exp_bit[exp_n] = b; exp_n++;
    endtask

    // R4: a byte always ends with a release, cut short on a bad bit
    task automatic e_byte(input logic [7:0] v, inout int ti, input bit fails,
                          input int fk, input int fp, output bit bad);
        bad = 0;
        for (int i = 7; i >= 0; i--) begin
            e_push(C_SEND, v[i]);
            if (fails && fk == 1 && ti == fp) begin ti++; bad = 1; break; end
            ti++;
        end
        e_push(C_REL, 1'b1);
    endtask

    task automatic e_ack(inout int ai, input bit fails, input int fk, input int fp, output bit bad);
        e_push(C_ACK, 1'b1);
        bad = fails && fk == 0 && ai == fp;
        ai++;
    endtask

    task automatic e_attempt(input bit rd, input logic [7:0] a, o, d, input bit fails,
                             input int fk, input int fp);
        int ti = 0, ai = 0;
        bit bad;
        e_push(C_START, 1'b1);
        e_byte(a, ti, fails, fk, fp, bad);   if (bad) begin e_push(C_CLEAR, 1'b1); return; end
        e_ack(ai, fails, fk, fp, bad);       if (bad) begin e_push(C_CLEAR, 1'b1); return; end
        e_byte(o, ti, fails, fk, fp, bad);   if (bad) begin e_push(C_CLEAR, 1'b1); return; end
        e_ack(ai, fails, fk, fp, bad);       if (bad) begin e_push(C_CLEAR, 1'b1); return; end
        if (rd) begin
            e_push(C_START, 1'b1);
            e_byte(a | 8'h01, ti, fails, fk, fp, bad); if (bad) begin e_push(C_CLEAR, 1'b1); return; end
            e_ack(ai, fails, fk, fp, bad);     if (bad) begin e_push(C_CLEAR, 1'b1); return; end
            for (int i = 0; i < 8; i++) e_push(C_RECV, 1'b1);
            e_push(C_SEND, 1'b1);
            if (fails && fk == 1 && ti == fp) begin e_push(C_CLEAR, 1'b1); return; end
        end else begin
            e_byte(d, ti, fails, fk, fp, bad); if (bad) begin e_push(C_CLEAR, 1'b1); return; end
            e_ack(ai, fails, fk, fp, bad);     if (bad) begin e_push(C_CLEAR, 1'b1); return; end
        end
        e_push(C_STOP, 1'b1);
    endtask

    task automatic run(input bit rd, input logic [7:0] a, o, d, s,
                       input int fn, input int fk, input int fp, input bit poke);
        int tries = rd ? RDT : WRT;
        int runs  = (fn + 1 < tries) ? fn + 1 : tries;
        bit fail_exp = (fn >= tries);
        int clears = 0, mism = -1, waitc = 0;
        string rq = rd ? "R1" : "R2";
        exp_n = 0;
        for (int at = 0; at < runs; at++) e_attempt(rd, a, o, d, at < fn, fk, fp);
        @(negedge clk);
        slave_val = s; f_n = fn; f_kind = fk; f_pos = fp;
        attempt = 0; tx_i = 0; ack_i = 0; rx_i = 0;
        log_n = 0; done_cnt = 0; bo_bad = 0; en_bad = 0;
        req = 1; req_rd = rd; dev_addr = a; reg_off = o; wr_data = d;
        @(negedge clk);
        req = 0;
        if (poke) begin
            repeat (30) @(negedge clk);
            req = 1; req_rd = !rd; dev_addr = ~a; reg_off = ~o; wr_data = ~d;
            @(negedge clk);
            req = 0;
        end
        while (done_cnt == 0 && waitc < 20000) begin @(negedge clk); waitc++; end
        repeat (25) @(negedge clk);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (mism < 0 && (log_op[i] != exp_op[i] ||
                (exp_op[i] == C_SEND && log_bit[i] != exp_bit[i]))) mism = i;
        end
        for (int i = 0; i < log_n; i++) if (log_op[i] == C_CLEAR) clears++;
        chk(log_n == exp_n, rq, "command count (R4 R10)", log_n, exp_n);
        chk(mism < 0, rq, "first mismatching command index (R4 R10)", mism, -1);
        chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        chk(done_fail == fail_exp, "R6", "fail flag", int'(done_fail), int'(fail_exp));
        chk(clears == (fail_exp ? tries : fn), "R5", "bus clears", clears, fail_exp ? tries : fn);
        chk(bo_bad == 0, "R5", "back-off windows with wrong tick count", bo_bad, 0);
        chk(en_bad == 0 && bb_en == 0, "R7", "bb_en faults/final level", en_bad + int'(bb_en), 0);
        if (!rd) chk(done_rd == 8'h00, "R3", "rd_data after write", int'(done_rd), 0);
        else if (!fail_exp) chk(done_rd == s, "R3", "rd_data after read", int'(done_rd), int'(s));
        if (poke) chk(done_cnt == 1 && mism < 0, "R8", "busy request ignored (done count)", done_cnt, 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        chk(bb_en == 0 && done == 0 && fail == 0 && cmd_valid == 0, "R11",
            "reset control outputs", int'({bb_en, done, fail, cmd_valid}), 0);
        chk(rd_data == 8'h00, "R11", "reset rd_data", int'(rd_data), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // directed corners
        run(1, 8'hA0, 8'h3C, 8'h00, 8'h81, 0, 0, 0, 1);    // R1 R3 R8
        run(0, 8'hA2, 8'h55, 8'hC3, 8'h00, 0, 0, 0, 1);    // R2 R8
        run(1, 8'hA0, 8'h10, 8'h00, 8'h5A, 3, 0, 2, 0);    // R5 nack on read-address ack
        run(1, 8'hAE, 8'h7F, 8'h00, 8'hFF, 10, 1, 3, 0);   // R4 R6 read exhausts budget
        run(0, 8'hA4, 8'h01, 8'h99, 8'h00, 1, 0, 2, 0);    // R6 write no retry
        run(0, 8'hA6, 8'h02, 8'h33, 8'h00, 1, 1, 20, 0);   // R4 bad bit in data byte
        run(1, 8'hA8, 8'h03, 8'h00, 8'h01, 1, 1, 24, 0);   // R5 bad NACK bit
        run(1, 8'hAA, 8'h04, 8'h00, 8'hC6, 9, 0, 0, 0);    // R6 success on last attempt
        // constrained random
        for (int k = 0; k < 16; k++) begin
            bit rd = $urandom_range(0, 1);
            int fk = $urandom_range(0, 1);
            int fn = ($urandom_range(0, 7) == 0) ? 10 : $urandom_range(0, 2);
            int fp = (fk == 0) ? $urandom_range(0, 2) : $urandom_range(0, rd ? 24 : 23);
            run(rd, {7'($urandom), 1'b0}, 8'($urandom), 8'($urandom), 8'($urandom),
                fn, fk, fp, fn == 0);
        end
        summary_and_end();
    end
endmodule